// File: doc/BRIEF.md
# Conversion Word Formatter and Serial Reader

This block takes a signed result from a converter's datapath and a coding-mode bit. It turns the result into a 24-bit output code, using straight binary in unipolar mode or two's complement in bipolar mode. A result outside the mode's range is clamped to the nearest limit code and marked with an over-range flag. The code and the flag are packed into a fixed 32-bit word. Every bit of that word that holds neither the code nor the flag reads as zero.

A host reads the word over a simple serial port with a clock, an active-low select and a data line. The word is captured from the result strobe only while the select is high, so a read in progress always sees a consistent word. While the select is low, the word leaves most significant bit first, and each falling edge of the serial clock advances it by one bit. Both serial inputs are sampled with the system clock and must be synchronous to it.

Top module: `convword_serializer`

## Requirements
- R1: With `bipolar`=0 and a result from 0 to 16777215 inclusive, the code equals the result in straight binary and the flag is 0.
- R2: With `bipolar`=0, a result above 16777215 gives code 0xFFFFFF with the flag set, and a negative result gives code 0x000000 with the flag set.
- R3: With `bipolar`=1 and a result from -8388608 to 8388607 inclusive, the code is the low 24 bits of the result in two's complement and the flag is 0.
- R4: With `bipolar`=1, a result above 8388607 gives code 0x7FFFFF with the flag set, and a result below -8388608 gives code 0x800000 with the flag set.
- R5: The 32-bit word holds the code in bits [31:8] and the flag in bit 2. Bits [7:3] and [1:0] are always 0.
- R6: When `csn` goes low, `sdo` shows word bit 31 before any serial clock edge. Each falling edge of `sclk` while `csn` is low moves on to the next lower bit.
- R7: `sdo` is 0 while `csn` is high. After 32 falling edges within one select period, `sdo` stays 0.
- R8: A `res_valid` strobe while `csn` is low is ignored. The current and all later reads return the word captured before, until a strobe arrives with `csn` high.
- R9: After reset the held word is all zeros, and each new select period shifts the held word from bit 31 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | One-cycle strobe marking a new result |
| res_data | input | 26 | Signed converter result |
| bipolar | input | 1 | Coding mode: 1 two's complement, 0 straight binary |
| sclk | input | 1 | Serial clock, idle low, synchronous to clk |
| csn | input | 1 | Active-low select |
| sdo | output | 1 | Serial data out |

## Verification
The hardest case to reach from the ports is a result strobe that arrives in the middle of a read. The stimulus lowers the select, shifts part of the word out, pulses the strobe with a different result, and then finishes the read. It then reads the word a second time and compares both reads with the earlier word. The coding rules are covered by results at each clamp boundary and one step on either side of it, plus a coarse sweep with an odd stride across the whole 26-bit signed range in both modes.

// File: rtl/convword_pkg.sv
package convword_pkg;

    localparam int RES_W    = 26;
    localparam int CODE_W   = 24;
    localparam int FRAME_W  = 32;
    localparam int FLAG_POS = 2;
    localparam int CNT_W    = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              ovr;
    } conv_code_t;

    typedef enum logic {
        MODE_UNI = 1'b0,
        MODE_BI  = 1'b1
    } code_mode_e;

    // Place the code at the top of the frame, the flag at FLAG_POS, zeros elsewhere.
    function automatic logic [FRAME_W-1:0] pack_frame(input conv_code_t c);
        logic [FRAME_W-1:0] f;
        f = '0;
        f[FRAME_W-1 -: CODE_W] = c.code;
        f[FLAG_POS]            = c.ovr;
        return f;
    endfunction

endpackage

// File: rtl/convword_coder.sv
module convword_coder
    import convword_pkg::*;
#(
    parameter int P_RES_W  = RES_W,
    parameter int P_CODE_W = CODE_W
) (
    input  logic signed [P_RES_W-1:0] res_in,
    input  code_mode_e                mode,
    output conv_code_t                cw
);

    localparam logic signed [P_RES_W-1:0] UNI_MAX =
        {{(P_RES_W-P_CODE_W){1'b0}}, {P_CODE_W{1'b1}}};
    localparam logic signed [P_RES_W-1:0] BI_MAX =
        {{(P_RES_W-P_CODE_W+1){1'b0}}, {(P_CODE_W-1){1'b1}}};
    localparam logic signed [P_RES_W-1:0] BI_MIN =
        {{(P_RES_W-P_CODE_W+1){1'b1}}, {(P_CODE_W-1){1'b0}}};
    localparam logic signed [P_RES_W-1:0] ZERO = '0;

    always_comb begin
        cw.ovr  = 1'b0;
        cw.code = res_in[P_CODE_W-1:0];
        if (mode == MODE_UNI) begin
            if (res_in > UNI_MAX) begin
                cw.code = {P_CODE_W{1'b1}};
                cw.ovr  = 1'b1;
            end else if (res_in < ZERO) begin
                cw.code = '0;
                cw.ovr  = 1'b1;
            end
        end else begin
            if (res_in > BI_MAX) begin
                cw.code = {1'b0, {(P_CODE_W-1){1'b1}}};
                cw.ovr  = 1'b1;
            end else if (res_in < BI_MIN) begin
                cw.code = {1'b1, {(P_CODE_W-1){1'b0}}};
                cw.ovr  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/convword_shifter.sv
module convword_shifter
    import convword_pkg::*;
#(
    parameter int P_FRAME_W = FRAME_W,
    parameter int P_CNT_W   = CNT_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [P_FRAME_W-1:0] word_in,
    input  logic                 sclk,
    input  logic                 csn,
    output logic [P_FRAME_W-1:0] hold_out,
    output logic                 sdo
);

    logic [P_FRAME_W-1:0] hold_q;
    logic [P_FRAME_W-1:0] shift_q;
    logic [P_CNT_W-1:0]   cnt_q;
    logic                 sclk_q;
    logic                 fall;
    logic                 done;

    assign fall = sclk_q & ~sclk & ~csn;
    assign done = (cnt_q == P_CNT_W'(P_FRAME_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            shift_q <= '0;
            cnt_q   <= '0;
            sclk_q  <= 1'b0;
        end else begin
            sclk_q <= sclk;
            if (csn) begin
                cnt_q   <= '0;
                shift_q <= hold_q;
                if (load) begin
                    hold_q <= word_in;
                end
            end else if (fall && !done) begin
                shift_q <= {shift_q[P_FRAME_W-2:0], 1'b0};
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

    assign hold_out = hold_q;
    assign sdo      = ~csn & ~done & shift_q[P_FRAME_W-1];

endmodule

// File: rtl/convword_serializer.sv
module convword_serializer
    import convword_pkg::*;
#(
    parameter int P_RES_W   = RES_W,
    parameter int P_CODE_W  = CODE_W,
    parameter int P_FRAME_W = FRAME_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      res_valid,
    input  logic signed [P_RES_W-1:0] res_data,
    input  logic                      bipolar,
    input  logic                      sclk,
    input  logic                      csn,
    output logic                      sdo
);

    localparam int L_CNT_W = $clog2(P_FRAME_W + 1);

    conv_code_t           cw;
    code_mode_e           mode;
    logic [P_FRAME_W-1:0] frame_word;
    logic [P_FRAME_W-1:0] hold_word;

    assign mode       = bipolar ? MODE_BI : MODE_UNI;
    assign frame_word = pack_frame(cw);

    convword_coder #(
        .P_RES_W (P_RES_W),
        .P_CODE_W(P_CODE_W)
    ) u_coder (
        .res_in(res_data),
        .mode  (mode),
        .cw    (cw)
    );

    convword_shifter #(
        .P_FRAME_W(P_FRAME_W),
        .P_CNT_W  (L_CNT_W)
    ) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (res_valid),
        .word_in (frame_word),
        .sclk    (sclk),
        .csn     (csn),
        .hold_out(hold_word),
        .sdo     (sdo)
    );

endmodule

// File: rtl/convword_chk.sv
module convword_chk
    import convword_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               sclk,
    input logic               csn,
    input logic               sdo,
    input logic [FRAME_W-1:0] hold_word
);

    logic [CNT_W-1:0] falls_q;
    logic             sclk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            falls_q   <= '0;
            sclk_prev <= 1'b0;
        end else begin
            sclk_prev <= sclk;
            if (csn)
                falls_q <= '0;
            else if (sclk_prev && !sclk && falls_q != CNT_W'(FRAME_W))
                falls_q <= falls_q + 1'b1;
        end
    end

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        csn |-> !sdo);

    // R7
    tail_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (falls_q == CNT_W'(FRAME_W)) |-> !sdo);

    // R8
    hold_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (!csn && $past(!csn)) |-> $stable(hold_word));

    // R5
    masked_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_word[7:3] == 5'd0) && (hold_word[1:0] == 2'd0));

    // R2 R4
    flag_limit_chk: assert property (@(posedge clk) disable iff (rst)
        hold_word[FLAG_POS] |->
            (hold_word[31:8] == 24'hFFFFFF || hold_word[31:8] == 24'h000000 ||
             hold_word[31:8] == 24'h7FFFFF || hold_word[31:8] == 24'h800000));

endmodule

bind convword_serializer convword_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .sclk     (sclk),
    .csn      (csn),
    .sdo      (sdo),
    .hold_word(hold_word)
);

// File: tb/convword_serializer_tb.sv
module convword_serializer_tb;

    logic              clk = 1'b0;
    logic              rst;
    logic              res_valid;
    logic signed [25:0] res_data;
    logic              bipolar;
    logic              sclk;
    logic              csn;
    logic              sdo;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    convword_serializer u_dut (
        .clk      (clk),
        .rst      (rst),
        .res_valid(res_valid),
        .res_data (res_data),
        .bipolar  (bipolar),
        .sclk     (sclk),
        .csn      (csn),
        .sdo      (sdo)
    );

    function automatic logic [31:0] model(input bit bi, input int x);
        logic [23:0] code;
        bit          ovr;
        ovr = 0;
        if (!bi) begin
            if (x > 16777215) begin code = 24'hFFFFFF; ovr = 1; end
            else if (x < 0)   begin code = 24'h000000; ovr = 1; end
            else code = x[23:0];
        end else begin
            if (x > 8388607)       begin code = 24'h7FFFFF; ovr = 1; end
            else if (x < -8388608) begin code = 24'h800000; ovr = 1; end
            else code = x[23:0];
        end
        return {code, 5'd0, ovr, 2'd0};
    endfunction

    function automatic string tag_for(input bit bi, input int x);
        if (!bi) return (x > 16777215 || x < 0) ? "R2" : "R1";
        return (x > 8388607 || x < -8388608) ? "R4" : "R3";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic convert(input bit bi, input int x);
        @(negedge clk);
        bipolar   = bi;
        res_data  = x[25:0];
        res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Read 32 bits; optionally strobe a new result after bit strobe_at.
    task automatic read_word(output logic [31:0] w, input int strobe_at, input int sx);
        logic tail;
        w = '0;
        @(negedge clk);
        csn = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 32; i++) begin
            w = {w[30:0], sdo};
            if (i == strobe_at) begin
                res_data  = sx[25:0];
                res_valid = 1'b1;
            end
            sclk = 1'b1;
            @(negedge clk);
            res_valid = 1'b0;
            sclk = 1'b0;
            @(negedge clk);
        end
        tail = 1'b0;
        for (int j = 0; j < 4; j++) begin
            tail |= sdo;
            sclk = 1'b1;
            @(negedge clk);
            sclk = 1'b0;
            @(negedge clk);
        end
        check("R7 tail after 32 bits", {31'd0, tail}, 32'd0);
        csn = 1'b1;
        @(negedge clk);
        check("R7 idle while deselected", {31'd0, sdo}, 32'd0);
        @(negedge clk);
    endtask

    task automatic conv_and_check(input bit bi, input int x);
        logic [31:0] w;
        convert(bi, x);
        read_word(w, -1, 0);
        check(tag_for(bi, x), w, model(bi, x));
    endtask

    initial begin
        #700000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        int uni_pts[] = '{0, 1, 2, 16777214, 16777215, 16777216, 16777217,
                          -1, -2, 33554431, -33554432, 8388608, 12345};
        int bi_pts[]  = '{0, 1, -1, 8388606, 8388607, 8388608, 8388609,
                          -8388607, -8388608, -8388609, -8388610,
                          33554431, -33554432, 4660};
        rst = 1'b1; res_valid = 1'b0; res_data = '0; bipolar = 1'b0;
        sclk = 1'b0; csn = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9: reset word is zero
        check("R9 idle sdo after reset", {31'd0, sdo}, 32'd0);
        read_word(w, -1, 0);
        check("R9 reset word", w, 32'd0);

        // R1 R2 boundaries
        foreach (uni_pts[k]) conv_and_check(1'b0, uni_pts[k]);
        // R3 R4 boundaries
        foreach (bi_pts[k]) conv_and_check(1'b1, bi_pts[k]);

        // Coarse sweep over the full 26-bit range, both modes (R1..R5)
        for (int m = 0; m < 2; m++) begin
            for (int x = -33554432; x < 33554432; x += 262147)
                conv_and_check(m[0], x);
        end

        // R5 R6: pattern with alternating bits, checked bit-exact
        conv_and_check(1'b0, 24'hA5A55A);
        conv_and_check(1'b1, -24'sd1);

        // R8: strobe during a read is ignored, now and afterwards
        convert(1'b0, 100);
        read_word(w, 10, 200);
        check("R8 read with mid-read strobe", w, model(1'b0, 100));
        read_word(w, -1, 0);
        check("R8 re-read after ignored strobe (R9 restart)", w, model(1'b0, 100));
        convert(1'b0, 200);
        read_word(w, -1, 0);
        check("R8 later strobe while idle takes effect", w, model(1'b0, 200));

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule